// File: doc/BRIEF.md
# Packed-Write Colour Palette Port

This block is the host-facing register port of a colour lookup table. Every palette entry holds a red, a green and a blue byte. The host reaches the table through four registers picked by a 2-bit select: an address register, a palette data register, a control data register and an overlay map register. Palette data writes are taken apart into bytes. The bytes go into the table as one continuous red-green-blue stream, and an internal component pointer moves the entry address forward on its own. A single wide write can therefore finish one entry and start the next.

A mode input chooses between two write widths. In wide mode every 32-bit word carries four components, taken from the most significant byte downwards. In narrow mode only the top byte of each word counts, so each write carries one component. The address register has a second job: it selects two indirect control registers. A command byte at index 6 holds the overlay-plane enable. A read mask at index 4 is ANDed with every pixel index before the table is read. A pixel lookup port returns the 24-bit colour one clock after it is given the index.

Top module: `cpal_port`

## Requirements
- R1: While reset is asserted, the entry address is 0, the component pointer is at red, the command byte is 0x00, the read mask is 0xFF, the overlay map byte is 0x00 and pix_rgb is 0.
- R2: In wide mode (narrow_mode=0), a palette data write (wr_sel=1) stores four components. Bits [31:24] are stored first, then [23:16], then [15:8], then [7:0]. Each component goes to the current entry and colour lane, with lanes taken in the order red, green, blue and the entry advancing after blue.
- R3: In narrow mode (narrow_mode=1), a palette data write stores one component, taken from bits [31:24]. Bits [23:0] have no effect.
- R4: The entry address increments after each blue component. Incrementing past the last entry wraps to entry 0.
- R5: An address write (wr_sel=0) loads the entry address and returns the component pointer to red. The value comes from bits [7:0] in wide mode and from bits [31:24] in narrow mode.
- R6: A control write (wr_sel=2) takes its byte from the same lane as R5. It loads the command byte when the address register holds 6, loads the read mask when the address register holds 4, and changes nothing when the address holds any other value.
- R7: ovl_enable is 1 when either of command bits [1:0] is set. Command 0x73 turns the overlay plane on and 0x70 turns it off.
- R8: pix_rgb equals {red, green, blue} of entry (pix_idx AND read mask), and it appears one clock after pix_idx is presented. A mask of 0x00 maps every index to entry 0.
- R9: When an entry is only partly written, the components already written keep their new values and the other components keep their old values.
- R10: An overlay write (wr_sel=3) loads ovl_map from the same byte lane as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| narrow_mode | input | 1 | 1: one component per write from the top byte; 0: four components per write |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 palette data, 2 control data, 3 overlay map |
| wr_data | input | DATA_W | Host write word |
| pix_idx | input | IDX_W | Pixel index for lookup |
| pix_rgb | output | 3*COMP_W | Looked-up colour {red, green, blue}, registered |
| cmd_value | output | COMP_W | Command byte |
| ovl_enable | output | 1 | Overlay plane enabled |
| ovl_map | output | COMP_W | Overlay map byte |

## Verification
The bench builds the port with IDX_W=4, which gives a 16-entry table. Twelve wide writes then cover every entry exactly once, and the thirteenth write shows the wrap onto entries 0 and 1. Because the table is small, every entry can be read back under several read masks, and narrow writes can start at each of the three component positions, including one that spans the top entry and entry 0. The indirect selectors 4 and 6 still fit into the 4-bit address.

// File: rtl/cpal_pkg.sv
package cpal_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_PAL  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_OVL  = 2'd3
    } reg_sel_e;

    localparam int NLANE      = 3;
    localparam int CMD_INDEX  = 6;
    localparam int MASK_INDEX = 4;
endpackage

// File: rtl/cpal_unpack.sv
// Maps the bytes of one palette write onto (entry, lane) slots and
// yields the pointer/address that follow the write.
module cpal_unpack #(
    parameter int DATA_W = 32,
    parameter int COMP_W = 8,
    parameter int IDX_W  = 8,
    localparam int NSLOT = DATA_W / COMP_W
) (
    input  logic                           narrow,
    input  logic [IDX_W-1:0]               cur_addr,
    input  logic [1:0]                     cur_ptr,
    input  logic [DATA_W-1:0]              data,
    output logic [NSLOT-1:0]               slot_vld,
    output logic [NSLOT-1:0][IDX_W-1:0]    slot_ent,
    output logic [NSLOT-1:0][1:0]          slot_lane,
    output logic [NSLOT-1:0][COMP_W-1:0]   slot_byte,
    output logic [IDX_W-1:0]               nxt_addr,
    output logic [1:0]                     nxt_ptr
);
    import cpal_pkg::*;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        always_comb begin
            int pos;
            pos          = int'(cur_ptr) + k;
            slot_vld[k]  = (k == 0) || !narrow;
            slot_lane[k] = 2'(pos % NLANE);
            slot_ent[k]  = cur_addr + IDX_W'(pos / NLANE);
            slot_byte[k] = data[DATA_W-1-k*COMP_W -: COMP_W];
        end
    end

    always_comb begin
        int cnt;
        cnt      = int'(cur_ptr) + (narrow ? 1 : NSLOT);
        nxt_ptr  = 2'(cnt % NLANE);
        nxt_addr = cur_addr + IDX_W'(cnt / NLANE);
    end
endmodule

// File: rtl/cpal_store.sv
// Three lane memories (red, green, blue) with multi-slot write and a
// registered lookup read.
module cpal_store #(
    parameter int COMP_W = 8,
    parameter int IDX_W  = 8,
    parameter int NSLOT  = 4,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [NSLOT-1:0]               slot_vld,
    input  logic [NSLOT-1:0][IDX_W-1:0]    slot_ent,
    input  logic [NSLOT-1:0][1:0]          slot_lane,
    input  logic [NSLOT-1:0][COMP_W-1:0]   slot_byte,
    input  logic [IDX_W-1:0]               rd_idx,
    output logic [3*COMP_W-1:0]            rd_rgb
);
    for (genvar l = 0; l < 3; l++) begin : g_lane
        logic [COMP_W-1:0] mem [ENTRIES];
        logic [COMP_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            for (int k = 0; k < NSLOT; k++) begin
                if (we && slot_vld[k] && slot_lane[k] == 2'(l)) begin
                    mem[slot_ent[k]] <= slot_byte[k];
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= mem[rd_idx];
        end

        // lane 0 (red) lands in the most significant byte
        assign rd_rgb[(2-l)*COMP_W +: COMP_W] = rd_q;
    end
endmodule

// File: rtl/cpal_port.sv
module cpal_port #(
    parameter int DATA_W = 32,
    parameter int COMP_W = 8,
    parameter int IDX_W  = 8,
    localparam int NSLOT = DATA_W / COMP_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   narrow_mode,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [IDX_W-1:0]       pix_idx,
    output logic [3*COMP_W-1:0]    pix_rgb,
    output logic [COMP_W-1:0]      cmd_value,
    output logic                   ovl_enable,
    output logic [COMP_W-1:0]      ovl_map
);
    import cpal_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0]  addr;
        logic [1:0]        ptr;
        logic [COMP_W-1:0] cmd;
        logic [COMP_W-1:0] mask;
        logic [COMP_W-1:0] ovl;
    } state_t;

    state_t st_d, st_q;

    logic [NSLOT-1:0]             slot_vld;
    logic [NSLOT-1:0][IDX_W-1:0]  slot_ent;
    logic [NSLOT-1:0][1:0]        slot_lane;
    logic [NSLOT-1:0][COMP_W-1:0] slot_byte;
    logic [IDX_W-1:0]             nxt_addr;
    logic [1:0]                   nxt_ptr;
    logic [COMP_W-1:0]            lane_byte;
    logic                         pal_we;

    cpal_unpack #(.DATA_W(DATA_W), .COMP_W(COMP_W), .IDX_W(IDX_W)) u_unpack (
        .narrow    (narrow_mode),
        .cur_addr  (st_q.addr),
        .cur_ptr   (st_q.ptr),
        .data      (wr_data),
        .slot_vld  (slot_vld),
        .slot_ent  (slot_ent),
        .slot_lane (slot_lane),
        .slot_byte (slot_byte),
        .nxt_addr  (nxt_addr),
        .nxt_ptr   (nxt_ptr)
    );

    assign pal_we = wr_en && (reg_sel_e'(wr_sel) == SEL_PAL);

    cpal_store #(.COMP_W(COMP_W), .IDX_W(IDX_W), .NSLOT(NSLOT)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (pal_we),
        .slot_vld  (slot_vld),
        .slot_ent  (slot_ent),
        .slot_lane (slot_lane),
        .slot_byte (slot_byte),
        .rd_idx    (pix_idx & st_q.mask[IDX_W-1:0]),
        .rd_rgb    (pix_rgb)
    );

    // register values ride in the top byte when narrow, low byte when wide
    assign lane_byte = narrow_mode ? wr_data[DATA_W-1 -: COMP_W] : wr_data[COMP_W-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_ADDR: begin
                    st_d.addr = lane_byte[IDX_W-1:0];
                    st_d.ptr  = 2'd0;
                end
                SEL_PAL: begin
                    st_d.addr = nxt_addr;
                    st_d.ptr  = nxt_ptr;
                end
                SEL_CTRL: begin
                    if (st_q.addr == IDX_W'(CMD_INDEX))  st_d.cmd  = lane_byte;
                    if (st_q.addr == IDX_W'(MASK_INDEX)) st_d.mask = lane_byte;
                end
                SEL_OVL: st_d.ovl = lane_byte;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr <= '0;
            st_q.ptr  <= '0;
            st_q.cmd  <= '0;
            st_q.mask <= '1;
            st_q.ovl  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_value  = st_q.cmd;
    assign ovl_enable = |st_q.cmd[1:0];
    assign ovl_map    = st_q.ovl;
endmodule

module cpal_port_chk #(
    parameter int DATA_W = 32,
    parameter int COMP_W = 8,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              narrow_mode,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [COMP_W-1:0] cmd_value,
    input logic              ovl_enable,
    input logic [COMP_W-1:0] ovl_map,
    input logic [IDX_W-1:0]  addr,
    input logic [1:0]        ptr
);
    logic [COMP_W-1:0] byte_in;
    assign byte_in = narrow_mode ? wr_data[DATA_W-1 -: COMP_W] : wr_data[COMP_W-1:0];

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (ptr == 2'd0 && addr == $past(byte_in[IDX_W-1:0]))); // R5
    AST_NARROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && narrow_mode) |=> (ptr == (($past(ptr) == 2'd2) ? 2'd0 : $past(ptr) + 2'd1))); // R3
    AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && !narrow_mode && ptr == 2'd2) |=> (ptr == 2'd0 && addr == $past(addr) + IDX_W'(2))); // R4
    AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && addr == IDX_W'(6)) |=> (cmd_value == $past(byte_in))); // R6
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'd2 && addr == IDX_W'(6)) |=> $stable(cmd_value)); // R6
    AST_OVL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovl_enable) |-> $past(wr_en && wr_sel == 2'd2)); // R7
    AST_OVL_MAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> (ovl_map == $past(byte_in))); // R10
endmodule

bind cpal_port cpal_port_chk #(.DATA_W(DATA_W), .COMP_W(COMP_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .narrow_mode (narrow_mode),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .cmd_value   (cmd_value),
    .ovl_enable  (ovl_enable),
    .ovl_map     (ovl_map),
    .addr        (st_q.addr),
    .ptr         (st_q.ptr)
);

// File: tb/test_cpal_port.sv
`timescale 1ns/1ps
module test_cpal_port;
    localparam int IDX_W = 4;
    localparam int ENT   = 1 << IDX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [IDX_W-1:0] pix_idx = '0;
    logic [23:0] pix_rgb;
    logic [7:0]  cmd_value;
    logic        ovl_enable;
    logic [7:0]  ovl_map;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] mr [ENT];
    logic [7:0] mg [ENT];
    logic [7:0] mb [ENT];
    int         m_addr = 0;
    int         m_ptr = 0;
    logic [7:0] m_cmd = 8'h00;
    logic [7:0] m_mask = 8'hFF;

    cpal_port #(.DATA_W(32), .COMP_W(8), .IDX_W(IDX_W)) i_cpal_port (
        .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .pix_idx(pix_idx), .pix_rgb(pix_rgb),
        .cmd_value(cmd_value), .ovl_enable(ovl_enable), .ovl_map(ovl_map)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        case (m_ptr)
            0: mr[m_addr] = b;
            1: mg[m_addr] = b;
            default: mb[m_addr] = b;
        endcase
        m_ptr++;
        if (m_ptr == 3) begin
            m_ptr  = 0;
            m_addr = (m_addr + 1) % ENT;
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        logic [7:0] lb;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        lb = narrow_mode ? d[31:24] : d[7:0];
        case (sel)
            2'd0: begin m_addr = int'(lb) % ENT; m_ptr = 0; end
            2'd1: begin
                if (narrow_mode) put(d[31:24]);
                else for (int j = 0; j < 4; j++) put(d[31-8*j -: 8]);
            end
            2'd2: begin
                if (m_addr == 6) m_cmd = lb;
                if (m_addr == 4) m_mask = lb;
            end
            default: ;
        endcase
    endtask

    task automatic look(input string req, input int idx);
        int e;
        @(negedge clk);
        pix_idx = IDX_W'(idx);
        @(negedge clk);
        e = idx & int'(m_mask) & (ENT - 1);
        check(req, {8'h0, pix_rgb}, {8'h0, mr[e], mg[e], mb[e]});
    endtask

    function automatic logic [31:0] pat(input int k);
        logic [31:0] w;
        for (int j = 0; j < 4; j++) w[31-8*j -: 8] = 8'((k * 4 + j) * 37 + 11);
        return w;
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 rgb", {8'h0, pix_rgb}, 32'h0);
        check("R1 cmd", {24'h0, cmd_value}, 32'h0);
        check("R1 ovl_map", {24'h0, ovl_map}, 32'h0);
        check("R1 ovl_enable", {31'h0, ovl_enable}, 32'h0);
        rst_n = 1'b1;

        // R2 R4 R5: wide fill of every entry, low-byte address with junk above
        narrow_mode = 1'b0;
        wr(2'd0, 32'hA5C3_7E00);
        for (int k = 0; k < 12; k++) wr(2'd1, pat(k));
        for (int i = 0; i < ENT; i++) look("R2 wide fill", i);
        // thirteenth word wraps onto entries 0 and 1 (R4)
        wr(2'd1, 32'h1122_3344);
        look("R4 wrap e0", 0);
        look("R4 wrap e1", 1);
        check("R4 e0 exp", {8'h0, mr[0], mg[0], mb[0]}, 32'h0011_2233);

        // R1 mask default FF: direct lookup already exercised; R8 mask sweep
        // R6: control writes at selectors 4 and 6, wide mode low byte
        wr(2'd0, 32'hFFFF_FF06);
        wr(2'd2, 32'h0000_0073);
        check("R6 cmd 73", {24'h0, cmd_value}, 32'h73);
        check("R7 ovl on", {31'h0, ovl_enable}, 32'h1);
        wr(2'd2, 32'h0000_0070);
        check("R7 ovl off", {31'h0, ovl_enable}, 32'h0);
        check("R6 cmd 70", {24'h0, cmd_value}, 32'h70);
        wr(2'd0, 32'h0000_0005);
        wr(2'd2, 32'h0000_0003);
        check("R6 ignored cmd", {24'h0, cmd_value}, 32'h70);
        look("R6 ignored mask", 13);
        wr(2'd0, 32'h0000_0004);
        for (int mi = 0; mi < 5; mi++) begin
            logic [7:0] mv;
            case (mi)
                0: mv = 8'h00;
                1: mv = 8'h05;
                2: mv = 8'h0A;
                3: mv = 8'h0C;
                default: mv = 8'hFF;
            endcase
            wr(2'd2, {24'h0, mv});
            for (int i = 0; i < ENT; i++) look("R8 mask sweep", i);
        end

        // R10 overlay map, both lanes
        wr(2'd3, 32'h0000_005A);
        check("R10 wide", {24'h0, ovl_map}, 32'h5A);
        narrow_mode = 1'b1;
        wr(2'd3, 32'hC3FF_FF00);
        check("R10 narrow", {24'h0, ovl_map}, 32'hC3);

        // R3 R5 R9: narrow writes from each start entry, junk in low bits
        for (int s = 0; s < ENT; s++) begin
            wr(2'd0, {8'(s), 24'h5A5A5A});
            wr(2'd1, {8'(s * 13 + 1), 24'hFFFFFF});
            look("R9 partial", s);
            wr(2'd1, {8'(s * 13 + 2), 24'h0000F0});
            wr(2'd1, {8'(s * 13 + 3), 24'h123456});
            look("R3 narrow entry", s);
        end
        // R4 narrow wrap across last entry
        wr(2'd0, {8'(ENT - 1), 24'h0});
        for (int j = 0; j < 4; j++) wr(2'd1, {8'(200 + j), 24'hABCDEF});
        look("R4 narrow wrap last", ENT - 1);
        look("R4 narrow wrap first", 0);

        // R2: wide write beginning at green of an entry
        wr(2'd0, {8'd9, 24'h0});
        wr(2'd1, {8'hE1, 24'h0});
        narrow_mode = 1'b0;
        wr(2'd1, 32'hD4C3_B2A1);
        look("R2 mid-entry e9", 9);
        look("R2 mid-entry e10", 10);
        check("R2 e10 exp", {8'h0, mr[10], mg[10], mb[10]}, {8'h0, 8'hB2, 8'hA1, mb[10]});

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule